// File: doc/BRIEF.md
# Dual Count-to-Limit Timer

This block holds two independent 32-bit up-counting timers behind a simple register bus. The bus has an address, write data, a write strobe, a read strobe and read data. Each timer has a count register, a limit register and a two-bit control register. The counter steps up by one on each clock. When it steps from the limit value, it goes back to zero. If its interrupt enable is set, that same step raises the timer's interrupt line.

The interrupt is a level. Any write to the timer's control register clears it, whatever value is written. A second control bit makes counting depend on the processor not being halted. With that bit set, the counter holds while the halt input is high.

Typical use is one timer armed as a periodic or one-shot event source. The other timer is given the maximum limit and acts as a free-running, wrapping cycle counter. Software can restart a period at any time by writing the count register.

Top module: `tmr_dual`

## Requirements
- R1: After reset, every control register reads 0, every count reads 0, every limit reads 0xFFFFFFFF, and both interrupt outputs are low.
- R2: The register addresses are fixed. Timer 0 has count at 0x21, control at 0x22 and limit at 0x23. Timer 1 has count at 0x100, control at 0x101 and limit at 0x102. While the read strobe is high, `rdata_o` shows the addressed register in the same cycle. Control reads back in bits 1:0 with zeros above. An unmapped address reads 0, and `rdata_o` is 0 whenever the read strobe is low.
- R3: While control bit 1 is 0, the count goes up by one on every clock edge, whatever the level of `halt_i`.
- R4: While control bit 1 is 1, the count changes only on edges where `halt_i` is low. It holds while `halt_i` is high, and no limit event occurs during that time.
- R5: A limit event is an advancing edge taken while the count equals the limit. On that edge the count becomes 0, so a period lasts limit+1 advancing edges.
- R6: When control bit 0 is 1, a limit event drives that timer's interrupt output high from the next cycle on. When bit 0 is 0, a limit event leaves the interrupt unchanged.
- R7: An interrupt that is high stays high until a write to that timer's control register. Such a write clears it on the following cycle, whatever data is written.
- R8: If a control-register write and an enabled limit event fall on the same edge, the interrupt is high after that edge.
- R9: A write to the count register loads the written value on that edge. It replaces the increment, and that edge produces no limit event.
- R10: With the limit at 0xFFFFFFFF and interrupts disabled, the count wraps from 0xFFFFFFFF to 0 and keeps running, and no interrupt is raised.
- R11: A write or a limit event on one timer has no effect on the registers or the interrupt of the other timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, acts on the rising clock edge |
| re_i | input | 1 | Read strobe, combinational read |
| halt_i | input | 1 | Processor halted indication |
| rdata_o | output | 32 | Read data, 0 when not reading |
| irq_o | output | 2 | Interrupt level, one bit per timer |

## Verification
The interrupt acknowledge (a control write) and the limit event can land on the same edge, and the set must beat the clear. A directed case sets up this collision. The timer is first frozen at count equal to limit using the halt qualifier. Halt is then released in the very cycle the control write is issued, and the interrupt must read high afterwards. Random runs with small limits and frequent control writes make the collision happen again many times. A cycle-level reference model in the bench judges every register and interrupt after each edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_N   = 2;
  localparam int unsigned CTL_W   = 2;
  localparam int unsigned CTL_IE  = 0;  // interrupt enable
  localparam int unsigned CTL_NH  = 1;  // count only when not halted
  localparam int unsigned OFS_CNT = 0;
  localparam int unsigned OFS_CTL = 1;
  localparam int unsigned OFS_LIM = 2;

  function automatic int unsigned tmr_base(int unsigned idx);
    return (idx == 0) ? 32'h21 : 32'h100;
  endfunction

  typedef struct packed {
    logic cnt_we;
    logic ctl_we;
    logic lim_we;
    logic cnt_re;
    logic ctl_re;
    logic lim_re;
  } tmr_sel_t;
endpackage

// File: rtl/tmr_dec.sv
module tmr_dec
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 32'h21
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  output tmr_sel_t          sel_o
);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(BASE + OFS_CNT);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BASE + OFS_CTL);
  localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(BASE + OFS_LIM);

  logic hit_cnt, hit_ctl, hit_lim;

  always_comb begin
    hit_cnt       = (addr_i == A_CNT);
    hit_ctl       = (addr_i == A_CTL);
    hit_lim       = (addr_i == A_LIM);
    sel_o.cnt_we  = we_i & hit_cnt;
    sel_o.ctl_we  = we_i & hit_ctl;
    sel_o.lim_we  = we_i & hit_lim;
    sel_o.cnt_re  = re_i & hit_cnt;
    sel_o.ctl_re  = re_i & hit_ctl;
    sel_o.lim_re  = re_i & hit_lim;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_sel_t          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              halt_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] lim_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cnt_q, lim_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              irq_q;
  logic              adv, wrap;

  always_comb begin
    adv  = ~ctl_q[CTL_NH] | ~halt_i;
    // a count write suppresses both the step and the limit event
    wrap = adv & ~sel_i.cnt_we & (cnt_q == lim_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '1;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (sel_i.cnt_we)  cnt_q <= wdata_i;
      else if (wrap)     cnt_q <= '0;
      else if (adv)      cnt_q <= cnt_q + 1'b1;
      if (sel_i.lim_we)  lim_q <= wdata_i;
      if (sel_i.ctl_we)  ctl_q <= wdata_i[CTL_W-1:0];
      // set wins over acknowledge
      if (wrap && ctl_q[CTL_IE]) irq_q <= 1'b1;
      else if (sel_i.ctl_we)     irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i.cnt_re)      rdata_o = cnt_q;
    else if (sel_i.ctl_re) rdata_o = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
    else if (sel_i.lim_re) rdata_o = lim_q;
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
  assign ctl_o = ctl_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              halt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [TMR_N-1:0]  irq_o
);
  tmr_sel_t                      sel    [TMR_N];
  logic [TMR_N-1:0][DATA_W-1:0]  cnt_q, lim_q, rd_part;
  logic [TMR_N-1:0][CTL_W-1:0]   ctl_q;
  logic [TMR_N-1:0]              cnt_we, ctl_we;

  for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
    tmr_dec #(.ADDR_W(ADDR_W), .BASE(tmr_base(g))) u_dec (
      .addr_i (addr_i),
      .we_i   (we_i),
      .re_i   (re_i),
      .sel_o  (sel[g])
    );
    tmr_core #(.DATA_W(DATA_W)) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel[g]),
      .wdata_i (wdata_i),
      .halt_i  (halt_i),
      .cnt_o   (cnt_q[g]),
      .lim_o   (lim_q[g]),
      .ctl_o   (ctl_q[g]),
      .irq_o   (irq_o[g]),
      .rdata_o (rd_part[g])
    );
    assign cnt_we[g] = sel[g].cnt_we;
    assign ctl_we[g] = sel[g].ctl_we;
  end

  // address windows are disjoint, so at most one part is nonzero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < TMR_N; i++) rdata_o = rdata_o | rd_part[i];
  end
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         halt_i,
  input logic [TMR_N-1:0]             irq_o,
  input logic [TMR_N-1:0][DATA_W-1:0] cnt_q,
  input logic [TMR_N-1:0][DATA_W-1:0] lim_q,
  input logic [TMR_N-1:0][CTL_W-1:0]  ctl_q,
  input logic [TMR_N-1:0]             cnt_we,
  input logic [TMR_N-1:0]             ctl_we
);
  for (genvar g = 0; g < TMR_N; g++) begin : g_chk
    logic adv;
    assign adv = ~ctl_q[g][CTL_NH] | ~halt_i;

    a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctl_q[g][CTL_NH] && !cnt_we[g] && cnt_q[g] != lim_q[g])
        |=> cnt_q[g] == $past(cnt_q[g]) + 1'b1);

    a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_q[g][CTL_NH] && halt_i && !cnt_we[g]) |=> $stable(cnt_q[g]));

    a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && !cnt_we[g] && cnt_q[g] == lim_q[g]) |=> cnt_q[g] == '0);

    a_r6_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[g]) |-> $past(ctl_q[g][CTL_IE] && cnt_q[g] == lim_q[g]));

    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[g] && !ctl_we[g]) |=> irq_o[g]);

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_we[g] && adv && !cnt_we[g] && ctl_q[g][CTL_IE] && cnt_q[g] == lim_q[g])
        |=> irq_o[g]);

    a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_we[g] && !ctl_we[g] && !irq_o[g]) |=> !irq_o[g]);
  end
endmodule

bind tmr_dual tmr_dual_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .halt_i (halt_i),
  .irq_o  (irq_o),
  .cnt_q  (cnt_q),
  .lim_q  (lim_q),
  .ctl_q  (ctl_q),
  .cnt_we (cnt_we),
  .ctl_we (ctl_we)
);

// File: tb/tmr_dual_test.sv
`timescale 1ns/1ps
module tmr_dual_test;
  localparam int DW = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0, re = 1'b0, halt = 1'b0;
  logic [DW-1:0] rdata;
  logic [1:0]    irq;

  int checks = 0, errors = 0;
  string ph = "R1";

  logic [DW-1:0] m_cnt [2];
  logic [DW-1:0] m_lim [2];
  logic [1:0]    m_ctl [2];
  logic          m_irq [2];

  tmr_dual #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .halt_i(halt), .rdata_o(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] base(int t);
    return (t == 0) ? AW'(12'h021) : AW'(12'h100);
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; re = 1'b1;
    #0.2;
    d = rdata;
    re = 1'b0;
  endtask

  // reference step, evaluated on the inputs present before the edge
  task automatic model_step();
    for (int t = 0; t < 2; t++) begin
      logic adv, cw, lw, kw, evt;
      adv = !m_ctl[t][1] || !halt;
      cw  = we && addr == base(t);
      kw  = we && addr == base(t) + 1;
      lw  = we && addr == base(t) + 2;
      evt = adv && !cw && m_cnt[t] == m_lim[t];
      if (evt && m_ctl[t][0]) m_irq[t] = 1'b1;
      else if (kw)            m_irq[t] = 1'b0;
      if (cw)       m_cnt[t] = wdata;
      else if (evt) m_cnt[t] = '0;
      else if (adv) m_cnt[t] = m_cnt[t] + 1;
      if (lw) m_lim[t] = wdata;
      if (kw) m_ctl[t] = wdata[1:0];
    end
  endtask

  task automatic check_all();
    logic [DW-1:0] d;
    for (int t = 0; t < 2; t++) begin
      rd(base(t),     d); check({ph, " count"},   d, m_cnt[t]);
      rd(base(t) + 1, d); check({ph, " control"}, d, {30'd0, m_ctl[t]});
      rd(base(t) + 2, d); check({ph, " limit"},   d, m_lim[t]);
      check({ph, " irq"}, {31'd0, irq[t]}, {31'd0, m_irq[t]});
    end
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    we = 1'b0;
    check_all();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    for (int t = 0; t < 2; t++) begin
      m_cnt[t] = '0; m_lim[t] = '1; m_ctl[t] = '0; m_irq[t] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    ph = "R1"; check_all();

    // R2: unmapped addresses and idle read strobe give zero
    rd(12'h024, d); check("R2 unmapped", d, '0);
    rd(12'h103, d); check("R2 unmapped", d, '0);
    addr = 12'h023; re = 1'b0; #0.2; check("R2 no strobe", rdata, '0);

    // R3: free counting ignores halt when qualifier is off
    ph = "R3"; halt = 1'b1; idle(5); halt = 1'b0; idle(3);

    // R4: qualifier on, halt freezes
    ph = "R4"; wr(12'h022, 32'h2); halt = 1'b1; idle(6); halt = 1'b0; idle(2);

    // R5/R6: period limit+1 with interrupt
    ph = "R5"; wr(12'h023, 32'd3); wr(12'h021, 32'd0); wr(12'h022, 32'h1);
    idle(5);
    ph = "R6"; check("R6 irq set", {31'd0, irq[0]}, 32'd1);
    // R7: held across further events, then cleared by a write
    ph = "R7"; idle(6); wr(12'h022, 32'hFFFF_FFFC);
    check("R7 irq cleared", {31'd0, irq[0]}, 32'd0);
    ph = "R6"; idle(6);  // interrupt disabled: events leave it low

    // R8: control write on the event edge
    ph = "R8"; wr(12'h022, 32'h3); halt = 1'b1;
    wr(12'h023, 32'd4); wr(12'h021, 32'd4);
    halt = 1'b0; wr(12'h022, 32'h1);
    check("R8 set wins", {31'd0, irq[0]}, 32'd1);

    // R9: count write overrides step and event
    ph = "R9"; wr(12'h022, 32'h1); wr(12'h021, 32'd4); wr(12'h021, 32'd2); idle(2);

    // R10: free-running wrap on timer 1
    ph = "R10"; wr(12'h101, 32'h0); wr(12'h102, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFD); idle(5);
    check("R10 no irq", {31'd0, irq[1]}, 32'd0);

    // R11: random traffic across both timers
    ph = "R11";
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      halt = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 5) == 0) begin
        int t, r;
        logic [DW-1:0] v;
        t = $urandom_range(0, 1);
        r = $urandom_range(0, 2);
        v = (r == 1) ? DW'($urandom_range(0, 3)) : DW'($urandom_range(0, 12));
        wr(base(t) + AW'(r), v);
      end else begin
        step();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule